// File: doc/BRIEF.md
# Hitless switching bandwidth sequencer

This block steers a clock-recovery loop through a change of reference so that the output phase drifts to the new reference instead of jumping. It stays dormant until the loop has locked for the first time. Once armed, a loss-of-lock indication starts a fixed sequence. The phase comparison is gated off and the loop is forced into its narrow bandwidth. Optionally, a feedback phase build-out step is requested and acknowledged. The phase comparison then comes back on. The block counts consecutive in-lock compare results, and a hold window runs after that count is reached. Only then does the loop return to wide bandwidth, and the sequencer arms itself again.

The hitless feature is fixed when the block is built: no sequencing, sequencing without build-out, or sequencing with build-out. Run-time enables can further suppress the sequence or the build-out step. An external narrow-bandwidth request always passes through to the bandwidth select. The loop filter and the switching of the filter resistor are outside this block.

Top module: `hitless_seq`

## Requirements
- R1: After reset the block is unarmed, with `pd_en_o`=1, `pbo_req_o`=0 and the sequencer's narrow select off. The block arms at the first clock edge that sees `cmp_valid_i`=1, `cmp_inlock_i`=1 and `lol_i`=0.
- R2: While armed, with the feature built in and `hs_en_i`=1, a clock edge that sees `lol_i`=1 drives `pd_en_o` to 0 and `nbw_o` to 1 from that edge on.
- R3: When build-out is built in (OPT_MODE=2) and `pbo_en_i`=1, the cycle after the phase detector turns off raises `pbo_req_o` while `pd_en_o` stays 0. Both hold until an edge sees `pbo_done_i`=1, after which `pbo_req_o`=0 and `pd_en_o`=1.
- R4: Without build-out (OPT_MODE=1, or `pbo_en_i`=0), `pd_en_o` is 0 for exactly one cycle and `pbo_req_o` stays 0.
- R5: After the phase detector is re-enabled, `nbw_o` stays 1 until RUN_LEN consecutive compare strobes (`cmp_valid_i`=1) report `cmp_inlock_i`=1. Cycles without a strobe neither add to the count nor break it.
- R6: Once the run completes, `nbw_o` stays 1 for HOLD_TICKS further cycles. The sequencer then drops its narrow select and is armed again, so a later loss of lock starts a new sequence.
- R7: A strobe with `cmp_inlock_i`=0 during the count sets the run back to zero.
- R8: `nbw_o` is 1 whenever `nbw_req_i`=1, in every state.
- R9: `lol_i` has no effect while the block is unarmed, or while `hs_en_i`=0.
- R10: With OPT_MODE=0 the block never sequences. With OPT_MODE=1 the block ignores `pbo_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lol_i | input | 1 | Loss-of-lock flag from the lock detector |
| cmp_valid_i | input | 1 | Strobe marking one phase compare result |
| cmp_inlock_i | input | 1 | Compare result is within the lock window (valid with strobe) |
| nbw_req_i | input | 1 | External narrow-bandwidth request |
| hs_en_i | input | 1 | Run-time enable for the hitless sequence |
| pbo_en_i | input | 1 | Run-time enable for the build-out step |
| pbo_done_i | input | 1 | Build-out step acknowledged |
| pd_en_o | output | 1 | Phase detector enable |
| nbw_o | output | 1 | Narrow loop bandwidth select |
| pbo_req_o | output | 1 | Build-out request |

## Verification
The bench builds three copies that share the same inputs: OPT_MODE=2, OPT_MODE=1 and OPT_MODE=0. Each copy uses RUN_LEN=8 and HOLD_TICKS=6, so the build-out step, the variant without build-out and the variant that is never sequenced are all compared on one stimulus. A short hold window brings the exact release cycle of the narrow select within easy reach. Several full sequences are run back to back, which exercises re-arming. A broken run of in-lock strobes is also driven, with the expected release placed a known number of cycles after the restarted run.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [2:0] {
        S_UNARMED = 3'd0,
        S_ARMED   = 3'd1,
        S_FREEZE  = 3'd2,
        S_BUILD   = 3'd3,
        S_RELOCK  = 3'd4,
        S_HOLD    = 3'd5
    } hs_state_e;

    typedef struct packed {
        hs_state_e state;
    } hs_ctl_t;

endpackage

// File: rtl/hs_run_counter.sv
module hs_run_counter #(
    parameter int RUN_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic valid_i,
    input  logic inlock_i,
    output logic done_o
);
    localparam int CW = $clog2(RUN_LEN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } run_t;

    run_t run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (!en_i) begin
            run_d.cnt = '0;
        end else if (valid_i) begin
            if (!inlock_i) begin
                run_d.cnt = '0;
            end else if (run_q.cnt != CW'(RUN_LEN)) begin
                run_d.cnt = run_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    assign done_o = en_i && (run_q.cnt == CW'(RUN_LEN));

    AST_RUN_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && valid_i && !inlock_i) |=> (run_q.cnt == '0)); // R7

    AST_RUN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(run_q.cnt) <= RUN_LEN)); // R5

endmodule

// File: rtl/hs_hold_timer.sv
module hs_hold_timer #(
    parameter int HOLD_TICKS = 35
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic expired_o
);
    localparam int TW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!en_i) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt != TW'(HOLD_TICKS - 1)) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign expired_o = en_i && (tmr_q.cnt == TW'(HOLD_TICKS - 1));

    AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tmr_q.cnt) < HOLD_TICKS)); // R6

    AST_HOLD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (tmr_q.cnt == '0) || en_i); // R6

endmodule

// File: rtl/hitless_seq.sv
module hitless_seq
    import hs_pkg::*;
#(
    parameter int OPT_MODE   = 2,
    parameter int RUN_LEN    = 8,
    parameter int HOLD_TICKS = 35
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lol_i,
    input  logic cmp_valid_i,
    input  logic cmp_inlock_i,
    input  logic nbw_req_i,
    input  logic hs_en_i,
    input  logic pbo_en_i,
    input  logic pbo_done_i,
    output logic pd_en_o,
    output logic nbw_o,
    output logic pbo_req_o
);
    localparam bit HS_BUILT  = (OPT_MODE != 0);
    localparam bit PBO_BUILT = (OPT_MODE == 2);

    hs_ctl_t ctl_d, ctl_q;
    logic    run_done;
    logic    hold_expired;
    logic    use_pbo;
    logic    seq_narrow;

    assign use_pbo = PBO_BUILT && pbo_en_i;

    hs_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (ctl_q.state == S_RELOCK),
        .valid_i  (cmp_valid_i),
        .inlock_i (cmp_inlock_i),
        .done_o   (run_done)
    );

    hs_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (ctl_q.state == S_HOLD),
        .expired_o (hold_expired)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            S_UNARMED: if (cmp_valid_i && cmp_inlock_i && !lol_i) ctl_d.state = S_ARMED;
            S_ARMED:   if (HS_BUILT && hs_en_i && lol_i) ctl_d.state = S_FREEZE;
            S_FREEZE:  ctl_d.state = use_pbo ? S_BUILD : S_RELOCK;
            S_BUILD:   if (pbo_done_i) ctl_d.state = S_RELOCK;
            S_RELOCK:  if (run_done) ctl_d.state = S_HOLD;
            S_HOLD:    if (hold_expired) ctl_d.state = S_ARMED;
            default:   ctl_d.state = S_UNARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= S_UNARMED;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign seq_narrow = (ctl_q.state == S_FREEZE) || (ctl_q.state == S_BUILD) ||
                        (ctl_q.state == S_RELOCK) || (ctl_q.state == S_HOLD);
    assign pd_en_o    = !((ctl_q.state == S_FREEZE) || (ctl_q.state == S_BUILD));
    assign pbo_req_o  = (ctl_q.state == S_BUILD);
    assign nbw_o      = seq_narrow || nbw_req_i;

    AST_PD_OFF_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_en_o |-> nbw_o); // R2

    AST_TRIGGER_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_en_o) |-> $past(ctl_q.state == S_ARMED && lol_i && hs_en_i)); // R9

    AST_BUILD_PD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        pbo_req_o |-> !pd_en_o); // R3

    AST_BUILD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (pbo_req_o && pbo_done_i) |=> (pd_en_o && !pbo_req_o)); // R3

    AST_FREEZE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == S_FREEZE && !use_pbo) |=> pd_en_o); // R4

    AST_RELEASE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == S_HOLD && hold_expired) |=> (ctl_q.state == S_ARMED)); // R6

endmodule

// File: tb/hitless_seq_bench.sv
`timescale 1ns/1ps
module hitless_seq_bench;
    localparam int RUN = 8;
    localparam int HOLD = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lol = 1'b0, cmp_valid = 1'b0, cmp_inlock = 1'b0, nbw_req = 1'b0;
    logic hs_en = 1'b1, pbo_en = 1'b1, pbo_done = 1'b0;
    logic pd2, nbw2, pbo2, pd1, nbw1, pbo1, pd0, nbw0, pbo0;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    hitless_seq #(.OPT_MODE(2), .RUN_LEN(RUN), .HOLD_TICKS(HOLD)) u_hitless_seq (
        .clk(clk), .rst_n(rst_n), .lol_i(lol), .cmp_valid_i(cmp_valid),
        .cmp_inlock_i(cmp_inlock), .nbw_req_i(nbw_req), .hs_en_i(hs_en),
        .pbo_en_i(pbo_en), .pbo_done_i(pbo_done),
        .pd_en_o(pd2), .nbw_o(nbw2), .pbo_req_o(pbo2));

    hitless_seq #(.OPT_MODE(1), .RUN_LEN(RUN), .HOLD_TICKS(HOLD)) u_hitless_seq_m1 (
        .clk(clk), .rst_n(rst_n), .lol_i(lol), .cmp_valid_i(cmp_valid),
        .cmp_inlock_i(cmp_inlock), .nbw_req_i(nbw_req), .hs_en_i(hs_en),
        .pbo_en_i(pbo_en), .pbo_done_i(pbo_done),
        .pd_en_o(pd1), .nbw_o(nbw1), .pbo_req_o(pbo1));

    hitless_seq #(.OPT_MODE(0), .RUN_LEN(RUN), .HOLD_TICKS(HOLD)) u_hitless_seq_m0 (
        .clk(clk), .rst_n(rst_n), .lol_i(lol), .cmp_valid_i(cmp_valid),
        .cmp_inlock_i(cmp_inlock), .nbw_req_i(nbw_req), .hs_en_i(hs_en),
        .pbo_en_i(pbo_en), .pbo_done_i(pbo_done),
        .pd_en_o(pd0), .nbw_o(nbw0), .pbo_req_o(pbo0));

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string tag, logic act, logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic strobe(bit lk);
        cmp_valid = 1'b1;
        cmp_inlock = lk;
        tick();
        cmp_valid = 1'b0;
        cmp_inlock = 1'b0;
    endtask

    // after the last in-lock strobe: HOLD edges still narrow, the next releases
    task automatic finish_run(string tag);
        tick(HOLD);
        check({tag, " R6 narrow during hold"}, nbw2, 1'b1);
        tick();
        check({tag, " R6 narrow released"}, nbw2, 1'b0);
        check({tag, " R6 mode1 narrow released"}, nbw1, 1'b0);
    endtask

    task automatic t_reset();
        tick();
        check("R1 reset pd_en", pd2, 1'b1);
        check("R1 reset narrow", nbw2, 1'b0);
        check("R1 reset pbo_req", pbo2, 1'b0);
    endtask

    task automatic t_unarmed_lol();
        lol = 1'b1;
        tick(4);
        check("R9 unarmed pd_en", pd2, 1'b1);
        check("R9 unarmed narrow", nbw2, 1'b0);
        check("R9 unarmed mode1 pd_en", pd1, 1'b1);
        lol = 1'b0;
        tick();
    endtask

    task automatic t_trigger_build();
        strobe(1'b1); // arms (R1)
        lol = 1'b1;
        tick();
        check("R2 pd off after trigger", pd2, 1'b0);
        check("R2 narrow after trigger", nbw2, 1'b1);
        check("R1 arm then trigger mode1", pd1, 1'b0);
        check("R10 mode0 never sequences", pd0, 1'b1);
        check("R10 mode0 narrow off", nbw0, 1'b0);
        tick();
        check("R3 build request raised", pbo2, 1'b1);
        check("R3 pd off during build", pd2, 1'b0);
        check("R4 mode1 pd back on", pd1, 1'b1);
        check("R10 mode1 ignores pbo_en", pbo1, 1'b0);
        lol = 1'b0;
        tick(3);
        check("R3 build request held", pbo2, 1'b1);
        pbo_done = 1'b1;
        tick();
        pbo_done = 1'b0;
        check("R3 pd on after done", pd2, 1'b1);
        check("R3 request dropped", pbo2, 1'b0);
        check("R5 narrow while relocking", nbw2, 1'b1);
        for (int i = 0; i < RUN; i++) strobe(1'b1);
        finish_run("build");
    endtask

    task automatic t_no_build();
        pbo_en = 1'b0;
        lol = 1'b1;
        tick();
        check("R6 rearmed trigger", pd2, 1'b0);
        tick();
        check("R4 single off cycle", pd2, 1'b1);
        check("R4 no request", pbo2, 1'b0);
        lol = 1'b0;
        for (int i = 0; i < RUN; i++) strobe(1'b1);
        finish_run("nobuild");
    endtask

    task automatic t_run_break();
        lol = 1'b1;
        tick(2);
        lol = 1'b0;
        for (int i = 0; i < 5; i++) strobe(1'b1);
        strobe(1'b0);
        for (int i = 0; i < RUN - 1; i++) begin
            strobe(1'b1);
            tick(); // idle gap between strobes (R5)
        end
        tick(HOLD + 2);
        check("R7 broken run not complete", nbw2, 1'b1);
        check("R5 pd on while counting", pd2, 1'b1);
        strobe(1'b1);
        finish_run("break R5");
    endtask

    task automatic t_hs_disabled();
        hs_en = 1'b0;
        lol = 1'b1;
        tick(4);
        check("R9 disabled pd_en", pd2, 1'b1);
        check("R9 disabled narrow", nbw2, 1'b0);
        hs_en = 1'b1;
        tick();
        check("R2 trigger after enable", pd2, 1'b0);
        lol = 1'b0;
        tick();
        for (int i = 0; i < RUN; i++) strobe(1'b1);
        finish_run("enable");
    endtask

    task automatic t_ext_narrow();
        nbw_req = 1'b1;
        tick();
        check("R8 ext narrow", nbw2, 1'b1);
        check("R8 ext narrow mode0", nbw0, 1'b1);
        check("R8 pd unaffected", pd2, 1'b1);
        nbw_req = 1'b0;
        tick();
        check("R8 ext narrow removed", nbw2, 1'b0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        t_reset();
        t_unarmed_lol();
        t_trigger_build();
        t_no_build();
        t_run_break();
        t_hs_disabled();
        t_ext_narrow();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule